// File: doc/BRIEF.md
# Shutdown Mode Pulse Signaller

Several boards share two active-low open-drain wires: a power-down wire and a sync wire. Each board pulls a wire low by enabling its open-drain driver, so a wire reads high only when no board is pulling it. This block runs one board's part of a coordinated shutdown or restart on those wires. A request that carries a mode code starts a fixed sequence. The block first pulls both wires low. For a restart it also gives a short release on the power-down wire. It then lets go of the sync wire and waits until every other board has let go too. It announces the chosen low-power mode as a count of low pulses on the sync wire, keeps a quiet period, and then raises `done`. The host uses `done` to enter its low-power state.

All timing comes from a one-millisecond strobe input (`ms_tick`), so every wait is measured in strobes and not in clock cycles. A request with a code outside the defined set is flagged on `err`. It still completes the barrier and the quiet period, but it sends no pulses.

Top module: `shutdown_signaller`

## Requirements
- R1: After reset, `pd_drive`, `sync_drive`, `busy`, `done` and `err` are all 0.
- R2: A `start` that is accepted while the block is idle or done sets `pd_drive`, `sync_drive` and `busy` to 1 in the cycle after the accepting clock edge.
- R3: For mode code 4 (restart), `pd_drive` stays 1 for PULSE_MS strobes after acceptance and then drops to 0. The block waits PULSE_MS more strobes before it releases the sync wire.
- R4: Once the sync wire is released (`sync_drive` = 0), the block holds there for as long as `sync_sense` reads 0. No pulse is sent and `done` stays 0.
- R5: Mode codes 0 (unknown), 1 (hibernate), 2 (deepsleep) and 3 (transport) send as many low pulses on the sync wire as the code's value. Each pulse is PULSE_MS strobes released followed by PULSE_MS strobes driven low.
- R6: After the last pulse, or directly after the barrier when no pulse is due, the block keeps the sync wire released for QUIET_MS strobes and then raises `done`. From the strobe after the barrier passes, this totals 2*PULSE_MS*n + QUIET_MS strobes, where n is the pulse count.
- R7: A restart (code 4) sends no pulses on the sync wire.
- R8: Codes 5 to 7 raise `err` and send no pulses, and the sequence still ends with `done` after the quiet period.
- R9: A `start` that arrives while `busy` is 1 is ignored, and the running sequence keeps its original mode.
- R10: `done` and `err` hold until the next accepted `start`. `pd_drive` stays 1 at the end for every mode except restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle strobe once per millisecond |
| start | input | 1 | Request to begin a sequence |
| mode | input | MODE_W | Requested mode code |
| sync_sense | input | 1 | Level read back from the shared sync wire |
| pd_drive | output | 1 | 1 enables the pull-down on the power-down wire |
| sync_drive | output | 1 | 1 enables the pull-down on the sync wire |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | Sequence finished; the host may power down |
| err | output | 1 | The finished or running request had an undefined code |

## Verification
The acceptance response (R2) is due one clock after the edge that samples `start`. The bench reads it half a cycle later. All the other results are due on the edge that consumes a given strobe, so the bench counts consumed strobes instead of clock cycles. It increments that count at the falling edge that follows each strobe, and it reads the outputs 1 ns after that same falling edge, so the count and the outputs always reflect the same set of rising edges. The bench releases the other boards' hold on the sync wire only in a cycle with no strobe pending. This keeps the barrier exit from absorbing a strobe, so the strobe total from release to `done` must equal 2*PULSE_MS*n + QUIET_MS exactly.

// File: rtl/shutdown_sig_pkg.sv
package shutdown_sig_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_PD_LOW,
        ST_PD_GAP,
        ST_BARRIER,
        ST_PULSE_REL,
        ST_PULSE_LOW,
        ST_QUIET
    } seq_state_e;

    localparam int MODE_UNKNOWN   = 0;
    localparam int MODE_HIBERNATE = 1;
    localparam int MODE_DEEPSLEEP = 2;
    localparam int MODE_TRANSPORT = 3;
    localparam int MODE_RESTART   = 4;
    localparam int MODE_LAST      = MODE_RESTART;

endpackage

// File: rtl/sdp_mode_decode.sv
module sdp_mode_decode
    import shutdown_sig_pkg::*;
#(
    parameter int MODE_W = 3
) (
    input  logic [MODE_W-1:0] mode,
    output logic              valid,
    output logic              restart,
    output logic [MODE_W-1:0] pulses
);

    localparam logic [MODE_W-1:0] CODE_LAST    = MODE_W'(MODE_LAST);
    localparam logic [MODE_W-1:0] CODE_RESTART = MODE_W'(MODE_RESTART);

    always_comb begin
        valid   = (mode <= CODE_LAST);
        restart = (mode == CODE_RESTART);
        // only the four pulse-coded modes carry a count; the rest send none
        pulses  = (valid && !restart) ? mode : '0;
    end

endmodule

// File: rtl/sdp_tick_timer.sv
module sdp_tick_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = tick && (cnt_q == (limit - CNT_W'(1)));
        cnt_d  = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = expire ? '0 : cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/shutdown_signaller.sv
module shutdown_signaller
    import shutdown_sig_pkg::*;
#(
    parameter int MODE_W   = 3,
    parameter int PULSE_MS = 1,
    parameter int QUIET_MS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ms_tick,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    input  logic              sync_sense,
    output logic              pd_drive,
    output logic              sync_drive,
    output logic              busy,
    output logic              done,
    output logic              err
);

    localparam int MAX_WAIT = (PULSE_MS > QUIET_MS) ? PULSE_MS : QUIET_MS;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);
    localparam logic [CNT_W-1:0] LIM_PULSE = CNT_W'(PULSE_MS);
    localparam logic [CNT_W-1:0] LIM_QUIET = CNT_W'(QUIET_MS);

    typedef struct packed {
        seq_state_e        state;
        logic [MODE_W-1:0] left;
        logic              err;
        logic              pd;
        logic              sync;
        logic              done;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic              dec_valid, dec_restart;
    logic [MODE_W-1:0] dec_pulses;
    logic              tmr_clear, tmr_expire;
    logic [CNT_W-1:0]  tmr_limit;
    logic              accept;

    sdp_mode_decode #(.MODE_W(MODE_W)) u_decode (
        .mode    (mode),
        .valid   (dec_valid),
        .restart (dec_restart),
        .pulses  (dec_pulses)
    );

    sdp_tick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (tmr_clear),
        .tick   (ms_tick),
        .limit  (tmr_limit),
        .expire (tmr_expire)
    );

    assign busy       = (r_q.state != ST_IDLE);
    assign accept     = start && !busy;
    assign tmr_limit  = (r_q.state == ST_QUIET) ? LIM_QUIET : LIM_PULSE;
    assign tmr_clear  = (r_d.state != r_q.state);
    assign pd_drive   = r_q.pd;
    assign sync_drive = r_q.sync;
    assign done       = r_q.done;
    assign err        = r_q.err;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.pd   = 1'b1;
                    r_d.sync = 1'b1;
                    r_d.done = 1'b0;
                    r_d.err  = !dec_valid;
                    r_d.left = dec_pulses;
                    r_d.state = dec_restart ? ST_PD_LOW : ST_ARM;
                end
            end
            ST_ARM: begin
                r_d.sync  = 1'b0;
                r_d.state = ST_BARRIER;
            end
            ST_PD_LOW: begin
                if (tmr_expire) begin
                    r_d.pd    = 1'b0;
                    r_d.state = ST_PD_GAP;
                end
            end
            ST_PD_GAP: begin
                if (tmr_expire) begin
                    r_d.sync  = 1'b0;
                    r_d.state = ST_BARRIER;
                end
            end
            ST_BARRIER: begin
                if (sync_sense) begin
                    r_d.state = (r_q.left == '0) ? ST_QUIET : ST_PULSE_REL;
                end
            end
            ST_PULSE_REL: begin
                if (tmr_expire) begin
                    r_d.sync  = 1'b1;
                    r_d.state = ST_PULSE_LOW;
                end
            end
            ST_PULSE_LOW: begin
                if (tmr_expire) begin
                    r_d.sync  = 1'b0;
                    r_d.left  = r_q.left - MODE_W'(1);
                    r_d.state = (r_q.left == MODE_W'(1)) ? ST_QUIET : ST_PULSE_REL;
                end
            end
            ST_QUIET: begin
                if (tmr_expire) begin
                    r_d.done  = 1'b1;
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, left: '0, err: 1'b0, pd: 1'b0, sync: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    AST_ACCEPT_PULLS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (pd_drive && sync_drive && busy)); // R2
    AST_PD_GAP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_PD_GAP) |-> !pd_drive); // R3
    AST_BARRIER_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_BARRIER && !sync_sense) |=> (r_q.state == ST_BARRIER && !sync_drive)); // R4
    AST_QUIET_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_QUIET) |-> !sync_drive); // R6
    AST_ERR_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && err) |-> (r_q.state != ST_PULSE_REL && r_q.state != ST_PULSE_LOW)); // R8
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(err) && !done)); // R9
    AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(err) && $stable(pd_drive))); // R10

endmodule

// File: tb/tb_shutdown_signaller.sv
module tb_shutdown_signaller;

    localparam int MODE_W   = 3;
    localparam int PULSE_MS = 1;
    localparam int QUIET_MS = 10;
    localparam int TICK_DIV = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_tick = 1'b0;
    logic start = 1'b0;
    logic [MODE_W-1:0] mode = '0;
    logic other_hold = 1'b1;
    logic sync_sense;
    logic pd_drive, sync_drive, busy, done, err;

    int checks = 0;
    int errors = 0;
    int consumed = 0;
    int div_cnt = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    // open-drain wire: high only when nobody pulls it
    assign sync_sense = !(sync_drive || other_hold);

    shutdown_signaller #(.MODE_W(MODE_W), .PULSE_MS(PULSE_MS), .QUIET_MS(QUIET_MS)) dut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .start(start), .mode(mode),
        .sync_sense(sync_sense), .pd_drive(pd_drive), .sync_drive(sync_drive),
        .busy(busy), .done(done), .err(err)
    );

    always @(negedge clk) begin
        if (ms_tick) consumed <= consumed + 1;
        div_cnt <= (div_cnt == TICK_DIV - 1) ? 0 : div_cnt + 1;
        ms_tick <= (div_cnt == TICK_DIV - 1);
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    function automatic int exp_pulses(input int m);
        return (m <= 3) ? m : 0;
    endfunction

    task automatic run_seq(input int m, input int hold_cycles, input bit poke_busy);
        int c0, cr, cd, npulse, guard;
        bit prev;
        step();
        mode = MODE_W'(m);
        start = 1'b1;
        other_hold = 1'b1;
        step();
        start = 1'b0;
        chk("R2 pd_drive", int'(pd_drive), 1);
        chk("R2 sync_drive", int'(sync_drive), 1);
        chk("R2 busy", int'(busy), 1);
        c0 = consumed;
        if (m == 4) begin
            guard = 0;
            while (pd_drive && guard < 1000) begin step(); guard++; end
            chk("R3 pd low strobes", consumed - c0, PULSE_MS);
        end
        for (int i = 0; i < hold_cycles; i++) begin
            if (poke_busy && i == 2) begin
                mode = MODE_W'((m + 1) % 8);
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            step();
        end
        start = 1'b0;
        chk("R4 sync released while held", int'(sync_drive), 0);
        chk("R4 no done while held", int'(done), 0);
        guard = 0;
        while (ms_tick && guard < 10) begin step(); guard++; end
        other_hold = 1'b0;
        cr = consumed;
        npulse = 0;
        prev = sync_drive;
        guard = 0;
        while (!done && guard < 5000) begin
            step();
            if (sync_drive && !prev) npulse++;
            prev = sync_drive;
            guard++;
        end
        cd = consumed;
        chk(m == 4 ? "R7 pulse count" : (m > 4 ? "R8 pulse count" : "R5 pulse count"),
            npulse, exp_pulses(m));
        chk(poke_busy ? "R9 strobes to done" : "R6 strobes to done",
            cd - cr, 2 * PULSE_MS * exp_pulses(m) + QUIET_MS);
        chk("R8 err", int'(err), (m > 4) ? 1 : 0);
        for (int i = 0; i < 7; i++) step();
        chk("R10 done held", int'(done), 1);
        chk("R10 pd end level", int'(pd_drive), (m == 4) ? 0 : 1);
        chk("R10 busy clear", int'(busy), 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) step();
        chk("R1 pd_drive", int'(pd_drive), 0);
        chk("R1 sync_drive", int'(sync_drive), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 err", int'(err), 0);
        rst_n = 1'b1;
        step();
        for (int m = 0; m < 8; m++) run_seq(m, 12, 1'b0);
        run_seq(3, 20, 1'b1);
        run_seq(4, 20, 1'b1);
        run_seq(6, 15, 1'b1);
        for (int k = 0; k < 20; k++) begin
            run_seq(int'($urandom_range(0, 7)), int'($urandom_range(4, 40)),
                    bit'($urandom_range(0, 1)));
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule